// File: doc/BRIEF.md
# Power-Fail Bus Lockout Controller

This block protects a small register-file peripheral from corrupted host traffic while its main supply collapses. An external power-detection circuit drives an active-low failure input. Once that input goes low, the controller raises a failure flag for the interrupt logic. It also emits a single pulse that tells the timekeeping logic to copy the current time into its save registers. It then waits out a delay measured in ticks of a slow timebase, nominally 1 ms per tick.

When the delay expires, the controller blocks the host bus. The chip-select, read, write and address lines reaching the register file are forced to their idle values, whatever the host drives. A host read or write that is still running at expiry is allowed to finish first. The lock holds until the failure input returns high. The input then releases the lock and clears the flag on the next synchronised clock.

The default delay is 32 ticks. Because the tick phase is free-running, the real interval lies between 31 and 32 tick periods. Software may replace it with its own tick count, including zero for immediate lockout.

Top module: `pwrfail_lockout`

## Requirements
- R1: After reset, lockout, pf_event and save_pulse are 0, and the bus outputs follow the bus inputs.
- R2: pf_n passes through a two-flop synchroniser. pf_event rises after the third rising clock edge following a fall of pf_n, and stays high while pf_n remains low, including throughout lockout.
- R3: save_pulse is high for exactly one cycle per power-fail event, in the same cycle in which pf_event rises.
- R4: With dly_en = 0, lockout is low 31*TICK_DIV cycles after pf_n falls and high by 32*TICK_DIV+8 cycles (a 32-tick delay).
- R5: With dly_en = 1, the delay is dly_ticks ticks. With dly_ticks = 0, lockout is low after the third and high after the fourth rising edge following the fall.
- R6: An access is in progress while cs_n_in is 0 and rd_n_in or wr_n_in is 0. If one is in progress when the delay expires, lockout stays low until the access ends, and rises at the first clock edge after the first cycle with no access.
- R7: While lockout is 1, cs_n_out, rd_n_out and wr_n_out are 1 and addr_out is all zeros, whatever the inputs are.
- R8: After pf_n returns high, lockout and pf_event are still 1 after the second rising edge and are 0 after the third.
- R9: If pf_n returns high before the delay expires, the sequence aborts: pf_event clears after the third edge and lockout never rises.
- R10: While lockout is 0, cs_n_out, rd_n_out, wr_n_out and addr_out equal their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_n | input | 1 | Asynchronous active-low power-fail indication |
| dly_en | input | 1 | 1 selects the programmed delay, 0 the 32-tick default |
| dly_ticks | input | DLY_W | Programmed delay in timebase ticks |
| cs_n_in | input | 1 | Host chip select, active low |
| rd_n_in | input | 1 | Host read strobe, active low |
| wr_n_in | input | 1 | Host write strobe, active low |
| addr_in | input | ADDR_W | Host register address |
| cs_n_out | output | 1 | Gated chip select to the register file |
| rd_n_out | output | 1 | Gated read strobe |
| wr_n_out | output | 1 | Gated write strobe |
| addr_out | output | ADDR_W | Gated address |
| lockout | output | 1 | Host bus is locked out |
| pf_event | output | 1 | Power-fail flag for the interrupt logic |
| save_pulse | output | 1 | One-cycle time-capture request |

## Verification
Two decisions can land on the same clock edge: the delay expiring and a host access still holding chip select and a strobe low. The bench opens an access before pf_n falls and uses a zero programmed delay, so expiry comes in the second cycle of the sequence, squarely inside the access. It checks that lockout stays low and the bus still passes the strobe during the held access. It then checks that lockout rises exactly one edge after the access is released.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_LOCK  = 2'd3
    } lk_state_e;
endpackage

// File: rtl/pfl_sync.sv
module pfl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 2'b11;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[1];
endmodule

// File: rtl/pfl_tick.sv
module pfl_tick #(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tk_t;

    tk_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == LAST) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + 1'b1;
            r_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick_o = r_q.tick;
endmodule

// File: rtl/pfl_fsm.sv
module pfl_fsm
    import pfl_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pf_s,
    input  logic             tick,
    input  logic             access,
    input  logic             dly_en,
    input  logic [DLY_W-1:0] dly_ticks,
    output logic             lock_o,
    output logic             flag_o,
    output logic             save_o
);
    localparam logic [DLY_W-1:0] DEF_TICKS = DLY_W'(1) << (DLY_W - 1);

    typedef struct packed {
        lk_state_e        state;
        logic [DLY_W-1:0] cnt;
        logic             flag;
        logic             save;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [DLY_W-1:0] target;

    always_comb begin
        target   = dly_en ? dly_ticks : DEF_TICKS;
        r_d      = r_q;
        r_d.save = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (!pf_s) begin
                    r_d.state = ST_ARM;
                    r_d.cnt   = '0;
                    r_d.flag  = 1'b1;
                    r_d.save  = 1'b1;
                end
            end
            ST_ARM: begin
                if (pf_s) begin
                    r_d.state = ST_IDLE;
                    r_d.flag  = 1'b0;
                end else if (r_q.cnt >= target) begin
                    r_d.state = access ? ST_DRAIN : ST_LOCK;
                end else if (tick) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (pf_s) begin
                    r_d.state = ST_IDLE;
                    r_d.flag  = 1'b0;
                end else if (!access) begin
                    r_d.state = ST_LOCK;
                end
            end
            default: begin
                if (pf_s) begin
                    r_d.state = ST_IDLE;
                    r_d.flag  = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.flag  <= 1'b0;
            r_q.save  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lock_o = (r_q.state == ST_LOCK);
    assign flag_o = r_q.flag;
    assign save_o = r_q.save;

    // R3
    save_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |=> !save_o);

    // R3
    save_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |-> (flag_o && $rose(flag_o)));

    // R6
    lock_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> !$past(access));

    // R2
    lock_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> flag_o);

    // R8
    release_on_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(pf_s));
endmodule

// File: rtl/pfl_gate.sv
module pfl_gate #(
    parameter int ADDR_W = 5
) (
    input  logic              lock,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              access_o
);
    assign cs_n_o   = cs_n_i | lock;
    assign rd_n_o   = rd_n_i | lock;
    assign wr_n_o   = wr_n_i | lock;
    assign access_o = !cs_n_i && (!rd_n_i || !wr_n_i);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        assign addr_o[i] = addr_i[i] & ~lock;
    end

    // R7
    lock_bus_idle_chk: assert property (@(posedge lock) 1'b1 |-> ##0 (cs_n_o && addr_o == '0))
        else $error("bus not idle under lockout");
endmodule

// File: rtl/pwrfail_lockout.sv
module pwrfail_lockout #(
    parameter int TICK_DIV = 16,
    parameter int DLY_W    = 6,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_n,
    input  logic              dly_en,
    input  logic [DLY_W-1:0]  dly_ticks,
    input  logic              cs_n_in,
    input  logic              rd_n_in,
    input  logic              wr_n_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cs_n_out,
    output logic              rd_n_out,
    output logic              wr_n_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic              lockout,
    output logic              pf_event,
    output logic              save_pulse
);
    logic pf_s, tick, access, lock;

    pfl_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pf_n),
        .sync_o (pf_s)
    );

    pfl_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    pfl_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pf_s     (pf_s),
        .tick     (tick),
        .access   (access),
        .dly_en   (dly_en),
        .dly_ticks(dly_ticks),
        .lock_o   (lock),
        .flag_o   (pf_event),
        .save_o   (save_pulse)
    );

    pfl_gate #(.ADDR_W(ADDR_W)) u_gate (
        .lock    (lock),
        .cs_n_i  (cs_n_in),
        .rd_n_i  (rd_n_in),
        .wr_n_i  (wr_n_in),
        .addr_i  (addr_in),
        .cs_n_o  (cs_n_out),
        .rd_n_o  (rd_n_out),
        .wr_n_o  (wr_n_out),
        .addr_o  (addr_out),
        .access_o(access)
    );

    assign lockout = lock;
endmodule

// File: tb/test_pwrfail_lockout.sv
module test_pwrfail_lockout;
    localparam int TD = 16;
    localparam int DW = 6;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_n = 1'b1;
    logic dly_en = 1'b0;
    logic [DW-1:0] dly_ticks = '0;
    logic cs_n_in = 1'b1, rd_n_in = 1'b1, wr_n_in = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic cs_n_out, rd_n_out, wr_n_out, lockout, pf_event, save_pulse;
    logic [AW-1:0] addr_out;

    always #4 clk = ~clk;

    pwrfail_lockout #(.TICK_DIV(TD), .DLY_W(DW), .ADDR_W(AW)) i_pwrfail_lockout (
        .clk(clk), .rst_n(rst_n), .pf_n(pf_n), .dly_en(dly_en), .dly_ticks(dly_ticks),
        .cs_n_in(cs_n_in), .rd_n_in(rd_n_in), .wr_n_in(wr_n_in), .addr_in(addr_in),
        .cs_n_out(cs_n_out), .rd_n_out(rd_n_out), .wr_n_out(wr_n_out), .addr_out(addr_out),
        .lockout(lockout), .pf_event(pf_event), .save_pulse(save_pulse)
    );

    typedef struct {
        int    cyc;
        int    sel;
        int    val;
        string tag;
    } item_t;

    item_t exq[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    int save_cnt = 0;
    int exp_saves = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(int sel);
        case (sel)
            0: return int'(lockout);
            1: return int'(pf_event);
            2: return int'(cs_n_out);
            3: return int'(rd_n_out);
            4: return int'(wr_n_out);
            5: return int'(addr_out);
            default: return save_cnt;
        endcase
    endfunction

    // monitor: counts capture pulses, pops and compares due items
    always @(negedge clk) begin
        if (rst_n && save_pulse) save_cnt = save_cnt + 1;
        while (exq.size() > 0 && exq[0].cyc <= cyc) begin
            item_t it;
            int act;
            it = exq.pop_front();
            act = observe(it.sel);
            total++;
            if (act != it.val) begin
                bad++;
                $display("FAIL %s sel=%0d cyc=%0d actual=%0d expected=%0d",
                         it.tag, it.sel, cyc, act, it.val);
            end
        end
    end

    // driver helper: expected value n edges from now
    task automatic push(int n, int sel, int val, string tag);
        item_t it;
        it.cyc = cyc + n;
        it.sel = sel;
        it.val = val;
        it.tag = tag;
        exq.push_back(it);
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (exq.size() > 0) @(negedge clk);
    endtask

    task automatic bus(logic c, logic r, logic w, logic [AW-1:0] a);
        cs_n_in = c; rd_n_in = r; wr_n_in = w; addr_in = a;
    endtask

    task automatic fall();
        pf_n = 1'b0;
        exp_saves++;
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        run(1);
        // R1 reset state, R10 passthrough
        bus(1'b0, 1'b0, 1'b1, 5'h15);
        push(1, 0, 0, "R1 lockout");
        push(1, 1, 0, "R1 pf_event");
        push(1, 6, 0, "R1 save count");
        push(1, 2, 0, "R10 cs pass");
        push(1, 3, 0, "R10 rd pass");
        push(1, 4, 1, "R10 wr pass");
        push(1, 5, 'h15, "R10 addr pass");
        drain();
        bus(1'b1, 1'b1, 1'b1, '0);

        // R4 default delay, R2 flag, R3 one pulse
        dly_en = 1'b0;
        fall();
        push(2, 1, 0, "R2 flag before sync");
        push(3, 1, 1, "R2 flag set");
        push(4, 6, exp_saves, "R3 single capture");
        push(31*TD, 0, 0, "R4 not yet locked");
        push(32*TD+8, 0, 1, "R4 locked");
        drain();
        // R7 inputs ignored while locked
        bus(1'b0, 1'b1, 1'b0, 5'h1F);
        push(1, 2, 1, "R7 cs blocked");
        push(1, 4, 1, "R7 wr blocked");
        push(1, 3, 1, "R7 rd blocked");
        push(1, 5, 0, "R7 addr blocked");
        push(1, 1, 1, "R2 flag held in lockout");
        drain();
        bus(1'b1, 1'b1, 1'b1, '0);
        // R8 release
        pf_n = 1'b1;
        push(2, 0, 1, "R8 still locked");
        push(3, 0, 0, "R8 released");
        push(3, 1, 0, "R8 flag cleared");
        push(4, 6, exp_saves, "R3 no extra capture");
        drain();
        run(2);

        // R5 zero programmed delay
        dly_en = 1'b1;
        dly_ticks = '0;
        fall();
        push(3, 0, 0, "R5 zero delay before");
        push(4, 0, 1, "R5 zero delay lock");
        push(6, 6, exp_saves, "R3 capture per event");
        drain();
        pf_n = 1'b1;
        run(5);

        // R5 programmed 4 ticks
        dly_ticks = 6'd4;
        fall();
        push(3*TD, 0, 0, "R5 four ticks before");
        push(4*TD+8, 0, 1, "R5 four ticks lock");
        drain();
        pf_n = 1'b1;
        run(5);

        // R6 access in progress at expiry
        dly_ticks = '0;
        bus(1'b0, 1'b0, 1'b1, 5'h0A);
        run(1);
        fall();
        push(10, 0, 0, "R6 held during access");
        push(10, 2, 0, "R6 access still passes");
        push(10, 3, 0, "R6 read still passes");
        run(12);
        bus(1'b1, 1'b1, 1'b1, '0);
        push(1, 0, 1, "R6 lock after access end");
        drain();
        pf_n = 1'b1;
        run(5);

        // R9 abort before expiry
        dly_ticks = 6'd20;
        fall();
        run(10);
        pf_n = 1'b1;
        push(2, 1, 1, "R9 flag before release");
        push(3, 1, 0, "R9 flag cleared");
        push(3, 0, 0, "R9 no lock");
        push(30*TD, 0, 0, "R9 never locked");
        push(30*TD, 6, exp_saves, "R3 total captures");
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule